// File: doc/BRIEF.md
# Motor Stall Protection Timer

This block guards a brushless motor driver against a stalled rotor. While the driver is commanded to run and the speed loop reports that it has not reached lock, a charge counter climbs by one on every timing tick. When the counter has reached a programmed threshold and the rotor is still unlocked, the block sets a trip latch. The latch output forces the low-side power switches off. The trip stays set until the driver is put into stop mode or the block is reset at power-up. It does not retry on its own.

Stop mode bleeds the counter down by a fixed, larger step on each tick. A short stop therefore leaves some residual count, and the next timeout comes sooner. A restart during the start-up transient behaves the same way. While running with lock achieved, the counter keeps its value. A configuration strap removes the whole function: the counter is held empty and the latch cannot set. The parameter `DIS_STEP` (default 22) sets the discharge step. The parameter `TICK_DIV` (default 1, one tick per clock) sets the tick rate. All timings below assume the defaults.

Top module: `mlp_lock_timer`

## Requirements
- R1: Start with the counter at zero, `prot_dis_i`=0 and a threshold T on `thr_i`. Drive `run_i`=1 and `unlocked_i`=1. `lowside_off_o` then stays 0 through the first T clock edges and becomes 1 after edge T+1.
- R2: Once `lowside_off_o` is 1, it stays 1 while `run_i`=1 and `prot_dis_i`=0, whatever the value of `unlocked_i`.
- R3: `run_i`=0 at a clock edge clears `lowside_off_o` at that edge.
- R4: Each clock edge with `run_i`=0 lowers the counter by 22, and the counter stops at zero without wrapping. After 50 charge edges and one stop edge, the counter holds 28, so a threshold of 100 trips at the 73rd following charge edge. A long stop leaves the counter empty, so the next trip comes exactly as in R1.
- R5: With `run_i`=1 and `unlocked_i`=0, the counter holds its value and the latch never sets, even when the counter is at or above the threshold.
- R6: While charging, the counter never rises above `thr_i`. After 100 charge edges with T=30 and one stop edge, the count is 8, so T=30 trips at the 23rd charge edge.
- R7: At a clock edge with `prot_dis_i`=1, the block clears the counter and the latch. `lowside_off_o` stays 0 while the strap is set. After the strap is released, timing starts from zero as in R1.
- R8: If `run_i` falls at the same edge where the trip condition would otherwise set the latch, stop takes priority and `lowside_off_o` stays 0.
- R9: With `thr_i`=0, the first clock edge with `run_i`=1 and `unlocked_i`=1 sets `lowside_off_o`.
- R10: While `rst_ni`=0 and right after it is released, `lowside_off_o` is 0 and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| run_i | input | 1 | 1 = run mode, 0 = stop mode |
| unlocked_i | input | 1 | 1 = motor speed outside the lock window |
| prot_dis_i | input | 1 | 1 = protection disabled |
| thr_i | input | CNT_W | Timeout threshold in ticks |
| lowside_off_o | output | 1 | Trip latch; 1 forces the low-side switches off |

## Verification
Two events can land on one clock edge: the count reaching the threshold, which would set the trip, and stop mode, which clears it. The bench provokes this by charging exactly up to the threshold and then dropping `run_i` on the edge that would trip. It expects `lowside_off_o` to stay 0 there, and expects a full normal timeout afterwards. Residual charge is judged only through the delay to the trip at the port: shortened after a one-edge stop, lengthened by neither a locked pause nor an earlier over-threshold charge.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_STOP   = 2'd1,
    MODE_HOLD   = 2'd2,
    MODE_CHARGE = 2'd3
  } mode_e;

  // disable strap dominates, then stop, then lock status
  function automatic mode_e decode_mode(logic run, logic unl, logic dis);
    if (dis)       return MODE_OFF;
    else if (!run) return MODE_STOP;
    else if (unl)  return MODE_CHARGE;
    else           return MODE_HOLD;
  endfunction
endpackage

// File: rtl/mlp_tick_gen.sv
module mlp_tick_gen #(
  parameter int TICK_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST_C = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (div_q == LAST_C) div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == '0);
endmodule

// File: rtl/mlp_charge_ctr.sv
module mlp_charge_ctr
  import mlp_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int DIS_STEP = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  mode_e            mode_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             at_thr_o
);
  localparam logic [CNT_W-1:0] STEP_C = CNT_W'(DIS_STEP);

  logic [CNT_W-1:0] cnt_q, chg_val, dis_val;

  assign chg_val = (cnt_q >= thr_i)  ? thr_i : cnt_q + 1'b1;
  assign dis_val = (cnt_q > STEP_C)  ? cnt_q - STEP_C : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case (mode_i)
        MODE_OFF:    cnt_q <= '0;
        MODE_STOP:   if (tick_i) cnt_q <= dis_val;
        MODE_CHARGE: if (tick_i) cnt_q <= chg_val;
        default:     cnt_q <= cnt_q;
      endcase
    end
  end

  assign at_thr_o = (cnt_q >= thr_i);

  AST_CHG_CAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == MODE_CHARGE) |=> (cnt_q <= $past(thr_i))); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOLD) |=> $stable(cnt_q)); // R5
  AST_DISCH_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP) |=> (cnt_q <= $past(cnt_q))); // R4
  AST_OFF_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |=> at_thr_o == (thr_i == '0) || $changed(thr_i)); // R7
endmodule

// File: rtl/mlp_trip_latch.sv
module mlp_trip_latch
  import mlp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  mode_e mode_i,
  input  logic  at_thr_i,
  output logic  trip_o
);
  logic trip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trip_q <= 1'b0;
    else if (mode_i == MODE_OFF || mode_i == MODE_STOP) trip_q <= 1'b0;
    else if (mode_i == MODE_CHARGE && tick_i && at_thr_i) trip_q <= 1'b1;
  end

  assign trip_o = trip_q;

  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP) |=> !trip_q); // R3
  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_q && (mode_i == MODE_HOLD || mode_i == MODE_CHARGE)) |=> trip_q); // R2
  AST_SET_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_q) |-> $past(mode_i == MODE_CHARGE && at_thr_i)); // R1
  AST_OFF_NO_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |=> !trip_q); // R7
endmodule

// File: rtl/mlp_lock_timer.sv
module mlp_lock_timer
  import mlp_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int DIS_STEP = 22,
  parameter int TICK_DIV = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             unlocked_i,
  input  logic             prot_dis_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             lowside_off_o
);
  mode_e mode;
  logic  tick, at_thr;

  assign mode = decode_mode(run_i, unlocked_i, prot_dis_i);

  mlp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  mlp_charge_ctr #(.CNT_W(CNT_W), .DIS_STEP(DIS_STEP)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .mode_i   (mode),
    .thr_i    (thr_i),
    .at_thr_o (at_thr)
  );

  mlp_trip_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .mode_i   (mode),
    .at_thr_i (at_thr),
    .trip_o   (lowside_off_o)
  );

  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !prot_dis_i) |=> !lowside_off_o); // R8
  AST_ZERO_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && run_i && unlocked_i && !prot_dis_i && thr_i == '0) |=> lowside_off_o); // R9
  AST_DIS_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_dis_i |=> !lowside_off_o); // R7
endmodule

// File: tb/mlp_lock_timer_tb_top.sv
module mlp_lock_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic run_i = 1'b0, unlocked_i = 1'b0, prot_dis_i = 1'b0;
  logic [CNT_W-1:0] thr_i = '0;
  logic lowside_off_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit    chk;
    logic  exp;
    string tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mlp_lock_timer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .unlocked_i(unlocked_i),
    .prot_dis_i(prot_dis_i), .thr_i(thr_i), .lowside_off_o(lowside_off_o)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s lowside_off_o act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // driver: one clock edge of stimulus, expected output after that edge
  task automatic step(input logic run, input logic unl, input logic dis,
                      input logic [CNT_W-1:0] thr, input bit chk,
                      input logic exp, input string tag);
    sb_item_t it;
    @(negedge clk);
    run_i = run; unlocked_i = unl; prot_dis_i = dis; thr_i = thr;
    it.chk = chk; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic steps(input int n, input logic run, input logic unl, input logic dis,
                       input logic [CNT_W-1:0] thr, input bit chk,
                       input logic exp, input string tag);
    for (int i = 0; i < n; i++) step(run, unl, dis, thr, chk, exp, tag);
  endtask

  // from count c0, threshold thr trips at charge edge k
  task automatic trip_at(input logic [CNT_W-1:0] thr, input int k, input string tag);
    steps(k - 1, 1'b1, 1'b1, 1'b0, thr, 1'b1, 1'b0, tag);
    step(1'b1, 1'b1, 1'b0, thr, 1'b1, 1'b1, tag);
  endtask

  task automatic drain(input string tag);
    steps(8, 1'b0, 1'b0, 1'b0, thr_i, 1'b1, 1'b0, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    sb_item_t it;
    #1;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      if (it.chk) check(lowside_off_o, it.exp, it.tag);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lowside_off_o, 1'b0, "R10 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check(lowside_off_o, 1'b0, "R10 after reset");

    // R1 basic timeout from zero; R10 counter starts empty
    trip_at(12'd10, 11, "R1");
    // R2 latch holds regardless of lock while running
    steps(5, 1'b1, 1'b0, 1'b0, 12'd10, 1'b1, 1'b1, "R2 locked");
    steps(3, 1'b1, 1'b1, 1'b0, 12'd10, 1'b1, 1'b1, "R2 unlocked");
    // R3 stop clears
    drain("R3");

    // R4 residual: 50 charge, 1 stop -> 28, trip at 73
    steps(50, 1'b1, 1'b1, 1'b0, 12'd100, 1'b1, 1'b0, "R4 charge");
    step(1'b0, 1'b0, 1'b0, 12'd100, 1'b1, 1'b0, "R4 stop");
    trip_at(12'd100, 73, "R4 residual");
    drain("R4");

    // R5 hold while locked: 30 + 40 locked, trip at 71
    steps(30, 1'b1, 1'b1, 1'b0, 12'd100, 1'b1, 1'b0, "R5 charge");
    steps(40, 1'b1, 1'b0, 1'b0, 12'd100, 1'b1, 1'b0, "R5 locked");
    trip_at(12'd100, 71, "R5 hold");
    drain("R4 floor");
    // R4 floor: after long stop count is zero, no wrap
    trip_at(12'd10, 11, "R4 floor");
    drain("R4");

    // R6 saturation at threshold
    steps(99, 1'b1, 1'b1, 1'b0, 12'd30, 1'b0, 1'b0, "R6");
    step(1'b1, 1'b1, 1'b0, 12'd30, 1'b1, 1'b1, "R6 tripped");
    step(1'b0, 1'b0, 1'b0, 12'd30, 1'b1, 1'b0, "R6 stop");
    trip_at(12'd30, 23, "R6 capped");
    drain("R6");

    // R7 disable strap
    steps(50, 1'b1, 1'b1, 1'b1, 12'd5, 1'b1, 1'b0, "R7 disabled");
    trip_at(12'd5, 6, "R7 released");
    step(1'b1, 1'b1, 1'b1, 12'd5, 1'b1, 1'b0, "R7 clears latch");
    trip_at(12'd5, 6, "R7 counter cleared");
    drain("R7");

    // R8 stop on the would-trip edge
    steps(10, 1'b1, 1'b1, 1'b0, 12'd10, 1'b1, 1'b0, "R8 charge");
    step(1'b0, 1'b1, 1'b0, 12'd10, 1'b1, 1'b0, "R8 stop wins");
    trip_at(12'd10, 11, "R8 after");
    drain("R8");

    // R9 zero threshold
    trip_at(12'd0, 1, "R9");
    drain("R9");

    // R5 at threshold but locked: no trip
    steps(10, 1'b1, 1'b1, 1'b0, 12'd10, 1'b1, 1'b0, "R5 charge");
    steps(5, 1'b1, 1'b0, 1'b0, 12'd10, 1'b1, 1'b0, "R5 locked at thr");
    step(1'b1, 1'b1, 1'b0, 12'd10, 1'b1, 1'b1, "R5 unlock trips");
    drain("R3");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule